// File: doc/BRIEF.md
# Configuration Parameter Access Controller

This block gives user logic a memory-like way to reach the configuration parameters of a device: the recorded cause of the last reload, the watchdog timeout, the watchdog enable, the selected image page and the flag that tells factory and application images apart. Internally those values sit behind a serial register path. A capture loads a shift register from the parameter store, the shift register is clocked one bit at a time, and an update cycle commits its contents back to the store. The controller runs that sequence so that user logic only has to name a parameter and wait.

User logic puts a 3-bit parameter code on `prm_sel`, pulses `rd_req` or `wr_req` for one cycle and waits for `busy` to fall. A read leaves the field right-aligned on `rd_data`. A write edits one field through a full capture, shift and update pass. The write commits only while the factory image is active. The controller also accepts a reload request on `reconfig` whenever it is idle, and passes the watchdog kick straight through.

Top module: `param_access_ctrl`

## Requirements
- R1: After reset `busy` is 0, the factory image is active, and every parameter reads back as zero.
- R2: An accepted request (`rd_req` or `wr_req` while `busy` is 0; a write wins if both are high) raises `busy` from the next cycle on. `busy` stays high until the operation ends, and `rd_data` changes only in the cycle in which `busy` falls.
- R3: The parameter codes are 000 cause (5 bits), 010 watchdog timeout (12 bits), 011 watchdog enable (1 bit), 100 page (3 bits) and 101 image flag (1 bit, 1 = application). Reads give the field zero-extended in the low bits of `rd_data`. Writes take the low bits of `wr_data`.
- R4: Codes 001, 110 and 111, and writes to codes 000 or 101, keep `busy` high for exactly one cycle, change nothing and leave `rd_data` at zero.
- R5: A write to code 010, 011 or 100 takes effect only while the factory image is active. In the application image it changes nothing.
- R6: While `busy` is high, `prm_sel`, `wr_data` and `reconfig` are ignored. A `reconfig` in the same cycle as an accepted request is also ignored.
- R7: A `reconfig` accepted while idle pulses `reconfig_go` in the next cycle. From the factory image it switches to the application image: the written timeout, enable and page become the active values and the cause reads 5'b00100 (bit 2). From the application image it returns to the factory image and the cause reads 5'b01000 (bit 3).
- R8: The asynchronous reset `rst_n` aborts an operation in progress. An aborted write leaves every parameter at its reset value.
- R9: `wd_kick` follows `timer_rst` at all times, including while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request pulse |
| wr_req | input | 1 | Write request pulse |
| prm_sel | input | 3 | Parameter code |
| wr_data | input | DW | Write value, right-aligned |
| reconfig | input | 1 | Image reload request |
| timer_rst | input | 1 | Watchdog kick from user logic |
| busy | output | 1 | Operation in progress |
| rd_data | output | DW | Read value, right-aligned |
| reconfig_go | output | 1 | One-cycle pulse for an accepted reload |
| wd_kick | output | 1 | Watchdog kick passed through |

## Verification
The bench changes the code, the data and `reconfig` in the middle of a long operation. A controller that resampled them would write the wrong field or reload in the middle of a shift. It writes narrow fields with all-ones data: a design that did not mask would read back junk in the upper bits. It also tries writes to read-only and illegal codes, and writes in the application image, since a missing guard would corrupt the cause or the committed settings. Finally, it resets in the middle of a write and reads back zero to show that the half-shifted word never reached the store.

// File: rtl/param_access_ctrl.sv
module param_access_ctrl #(
  parameter int DW  = 12,
  parameter int STW = 5,
  parameter int PGW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [2:0]    prm_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          reconfig,
  input  logic          timer_rst,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          reconfig_go,
  output logic          wd_kick
);
  localparam int TLO  = PGW;
  localparam int EBIT = PGW + DW;
  localparam int ABIT = EBIT + 1;
  localparam int SLO  = ABIT + 1;
  localparam int WW   = SLO + STW;
  localparam int CNW  = $clog2(WW + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHORT, S_CAP, S_SHF, S_RDONE, S_UPD} st_t;

  st_t            st;
  logic [PGW-1:0] upd_pg, ctl_pg;
  logic [DW-1:0]  upd_tmo, ctl_tmo;
  logic           upd_en, ctl_en, app;
  logic [STW-1:0] stat;
  logic [WW-1:0]  sr, acc, edw, cap_word;
  logic [DW-1:0]  op_dat;
  logic [2:0]     op_code;
  logic           op_wr;
  logic [CNW-1:0] cnt;
  logic           accept, go_long;

  function automatic logic rd_ok(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic wr_ok(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  function automatic logic [WW-1:0] edit(input logic [WW-1:0] w, input logic [2:0] c,
                                         input logic [DW-1:0] d);
    logic [WW-1:0] r;
    r = w;
    case (c)
      3'd2: r[TLO +: DW] = d;
      3'd3: r[EBIT] = d[0];
      3'd4: r[0 +: PGW] = d[PGW-1:0];
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] pick(input logic [WW-1:0] w, input logic [2:0] c);
    logic [DW-1:0] r;
    r = '0;
    case (c)
      3'd0: r[STW-1:0] = w[SLO +: STW];
      3'd2: r = w[TLO +: DW];
      3'd3: r[0] = w[EBIT];
      3'd4: r[PGW-1:0] = w[0 +: PGW];
      3'd5: r[0] = w[ABIT];
      default: ;
    endcase
    return r;
  endfunction

  assign wd_kick  = timer_rst;
  assign accept   = (rd_req || wr_req) && !busy;
  assign go_long  = wr_req ? wr_ok(prm_sel) : rd_ok(prm_sel);
  assign cap_word = app ? {stat, app, ctl_en, ctl_tmo, ctl_pg}
                        : {stat, app, upd_en, upd_tmo, upd_pg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      busy <= 1'b0;
      rd_data <= '0;
      reconfig_go <= 1'b0;
      upd_pg <= '0; upd_tmo <= '0; upd_en <= 1'b0;
      ctl_pg <= '0; ctl_tmo <= '0; ctl_en <= 1'b0;
      app <= 1'b0;
      stat <= '0;
      sr <= '0; acc <= '0; edw <= '0;
      op_dat <= '0; op_code <= '0; op_wr <= 1'b0;
      cnt <= '0;
    end else begin
      reconfig_go <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            busy    <= 1'b1;
            op_wr   <= wr_req;
            op_code <= prm_sel;
            op_dat  <= wr_data;
            st      <= go_long ? S_CAP : S_SHORT;
          end else if (reconfig) begin
            reconfig_go <= 1'b1;
            if (app) begin
              app  <= 1'b0;
              stat <= STW'(8);
            end else begin
              app     <= 1'b1;
              stat    <= STW'(4);
              ctl_pg  <= upd_pg;
              ctl_tmo <= upd_tmo;
              ctl_en  <= upd_en;
            end
          end
        end
        S_SHORT: begin
          busy    <= 1'b0;
          rd_data <= '0;
          st      <= S_IDLE;
        end
        S_CAP: begin
          sr  <= cap_word;
          edw <= edit(cap_word, op_code, op_dat);
          cnt <= '0;
          st  <= S_SHF;
        end
        S_SHF: begin
          sr  <= {edw[cnt], sr[WW-1:1]};
          acc <= {sr[0], acc[WW-1:1]};
          cnt <= cnt + 1'b1;
          if (cnt == CNW'(WW - 1)) st <= op_wr ? S_UPD : S_RDONE;
        end
        S_RDONE: begin
          rd_data <= pick(acc, op_code);
          busy    <= 1'b0;
          st      <= S_IDLE;
        end
        S_UPD: begin
          if (!app) begin
            upd_pg  <= sr[0 +: PGW];
            upd_tmo <= sr[TLO +: DW];
            upd_en  <= sr[EBIT];
          end
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/param_access_ctrl_chk.sv
module param_access_ctrl_chk #(
  parameter int DW  = 12,
  parameter int LIM = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          wr_req,
  input logic [2:0]    prm_sel,
  input logic          reconfig,
  input logic          busy,
  input logic [DW-1:0] rd_data,
  input logic          reconfig_go
);
  logic [7:0] busy_cnt;
  logic       short_op;

  assign short_op = wr_req ? !((prm_sel == 3'd2) || (prm_sel == 3'd3) || (prm_sel == 3'd4))
                           : ((prm_sel == 3'd1) || (prm_sel == 3'd6) || (prm_sel == 3'd7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 8'd1;
    else busy_cnt <= '0;
  end

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) && !busy |=> busy);

  assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $fell(busy));

  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < 8'(LIM));

  assert_short_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) && !busy && short_op |=> busy ##1 !busy);

  assert_rcfg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !reconfig_go);

  assert_rcfg_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig && !busy && !rd_req && !wr_req |=> reconfig_go);
endmodule

bind param_access_ctrl param_access_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/param_access_ctrl_bench.sv
module param_access_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0, wr_req = 1'b0, reconfig = 1'b0, timer_rst = 1'b0;
  logic [2:0]  prm_sel = '0;
  logic [11:0] wr_data = '0;
  logic        busy, reconfig_go, wd_kick;
  logic [11:0] rd_data;

  int checks = 0, failures = 0;
  int exp_q[$];
  string tag_q[$];
  logic prev_busy = 1'b0;
  bit done = 1'b0;

  param_access_ctrl u_param_access_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_busy && !busy && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e >= 0) check(t, int'(rd_data), e);
    end
    prev_busy <= busy;
  end

  task automatic op(input bit is_wr, input logic [2:0] code, input logic [11:0] d,
                    input int exp, input string tag, input int short_chk = 0);
    int n;
    @(negedge clk);
    rd_req = !is_wr; wr_req = is_wr; prm_sel = code; wr_data = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    check({tag, " busy rise"}, int'(busy), 1);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    if (short_chk != 0) check({tag, " one busy cycle"}, n, 1);
  endtask

  task automatic rd(input logic [2:0] code, input int exp, input string tag);
    op(1'b0, code, 12'h000, exp, tag);
  endtask

  task automatic wr(input logic [2:0] code, input logic [11:0] d, input string tag);
    op(1'b1, code, d, -1, tag);
  endtask

  task automatic do_reconfig(input string tag);
    @(negedge clk);
    reconfig = 1'b1;
    @(negedge clk);
    reconfig = 1'b0;
    check(tag, int'(reconfig_go), 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    rd(3'd0, 0, "R1 cause at reset");
    rd(3'd5, 0, "R1 image flag at reset");
    rd(3'd4, 0, "R1 page at reset");
    rd(3'd2, 0, "R1 timeout at reset");

    wr(3'd2, 12'hABC, "R5 write timeout");
    rd(3'd2, 12'hABC, "R2 R5 read timeout");
    wr(3'd3, 12'hFFF, "R3 write enable");
    rd(3'd3, 1, "R3 enable masked");
    wr(3'd4, 12'h7FD, "R3 write page");
    rd(3'd4, 5, "R3 page masked");
    rd(3'd2, 12'hABC, "R3 timeout untouched");

    op(1'b0, 3'd1, 12'h0, 0, "R4 illegal read 001", 1);
    op(1'b1, 3'd6, 12'hFFF, 0, "R4 illegal write 110", 1);
    op(1'b1, 3'd0, 12'h01F, 0, "R4 write to cause", 1);
    rd(3'd0, 0, "R4 cause unchanged");
    op(1'b1, 3'd5, 12'h001, 0, "R4 write to image flag", 1);
    rd(3'd5, 0, "R4 image flag unchanged");

    @(negedge clk);
    wr_req = 1'b1; prm_sel = 3'd2; wr_data = 12'h111;
    exp_q.push_back(-1); tag_q.push_back("R6 write");
    @(negedge clk);
    wr_req = 1'b0; prm_sel = 3'd3; wr_data = 12'hFFE;
    repeat (3) @(negedge clk);
    timer_rst = 1'b1;
    #1 check("R9 kick while busy", int'(wd_kick), 1);
    timer_rst = 1'b0;
    #1 check("R9 kick release", int'(wd_kick), 0);
    while (busy) @(negedge clk);
    rd(3'd2, 12'h111, "R6 data latched at accept");
    rd(3'd3, 1, "R6 code latched at accept");

    @(negedge clk);
    rd_req = 1'b1; prm_sel = 3'd5;
    exp_q.push_back(0); tag_q.push_back("R6 read during reconfig");
    @(negedge clk);
    rd_req = 1'b0; reconfig = 1'b1; prm_sel = 3'd0;
    while (busy) begin
      @(negedge clk);
      if (busy) check("R6 no reload while busy", int'(reconfig_go), 0);
    end
    reconfig = 1'b0;
    @(negedge clk);
    check("R6 reload ignored", int'(reconfig_go), 0);
    rd(3'd5, 0, "R6 still factory");

    do_reconfig("R7 pulse to application");
    @(negedge clk);
    check("R7 pulse single", int'(reconfig_go), 0);
    rd(3'd5, 1, "R7 image flag application");
    rd(3'd0, 4, "R7 cause bit 2");
    rd(3'd2, 12'h111, "R7 timeout active");
    rd(3'd4, 5, "R7 page active");

    wr(3'd2, 12'h222, "R5 app write");
    rd(3'd2, 12'h111, "R5 app write blocked");

    do_reconfig("R7 pulse to factory");
    rd(3'd5, 0, "R7 back to factory");
    rd(3'd0, 8, "R7 cause bit 3");
    rd(3'd2, 12'h111, "R7 factory keeps update");

    @(negedge clk);
    wr_req = 1'b1; prm_sel = 3'd2; wr_data = 12'h333;
    @(negedge clk);
    wr_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8 busy cleared by reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(3'd2, 0, "R8 aborted write");
    rd(3'd0, 0, "R8 cause after reset");

    repeat (3) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule